// File: doc/BRIEF.md
# Banked Stencil Scratchpad

This block is an on-chip scratchpad built from many independent banks, each with one read/write port and one read-only port. A three-dimensional data set is laid out so that every bank holds one y-plane. Inside a bank, a word sits at row z and column x. With this layout, a reach-4 stencil around a centre point (x, y, z) is spread over nine banks. The centre, the eight x-neighbours and the eight z-neighbours all live in bank y. The eight y-neighbours live one per bank in the banks on either side of y.

A gather starts with one pulse that carries the centre coordinate. The block then reads the centre bank on both ports for nine cycles, so it fetches two plane points per cycle. In the first of those cycles it also reads the eight y-neighbour banks in parallel. All 25 points therefore come out in nine beats instead of 25.

A fill port loads words into the banks one at a time, from whatever moves tiles in. A fill aimed at a bank that the gather reads in that cycle waits. A fill aimed at any other bank completes at once. Coordinates wrap around modulo the bank count, the row count and the column count, so a stencil near an edge reads the opposite edge.

Top module: `stencil_scratchpad`

## Requirements
- R1: After reset `outValid`, `outValidB`, `yValid`, `outLast` and `busy` are low, and `fillReady` is high.
- R2: A fill with `fillValid` and `fillReady` both high at a clock edge stores `fillData` in bank `fillBank`, at row `fillRow`, column `fillCol`. A gather centred at (x, y, z) reads bank y, row z, column x for its centre.
- R3: Point indices are 0 to 24. Index 0 is the centre. Indices 1 to 8 are x-neighbours at distance (i+1)/2, negative when i is odd. Indices 9 to 16 are z-neighbours, coded the same way with i-8. Indices 17 to 24 are y-neighbours: with j = i-17, the distance is j/2+1, negative when j is even.
- R4: Beat k (0 to 8) carries point 2k on lane A. On beats 0 to 7 it also carries point 2k+1 on lane B, with `outValidB` high. Beat 8 has `outValidB` low and `outLast` high. `outLast` is low on every other beat.
- R5: On beat 0 only, `yValid` is high and `yData` bits [j*WIDTH +: WIDTH] hold point 17+j, for j = 0 to 7.
- R6: A start pulse sampled while `busy` is low makes `busy` high for exactly 9 cycles. Beat 0 appears two clock edges after the start edge, and beats 1 to 8 follow on consecutive cycles.
- R7: Neighbour coordinates wrap modulo COLS in x, modulo ROWS in z and modulo NUM_BANKS in y.
- R8: A start pulse sampled while `busy` is high is ignored: it produces no beats and does not disturb the gather in progress.
- R9: `fillReady` is low while the addressed bank is being read in that cycle. This holds for the centre bank during all 9 read cycles and for a y-neighbour bank during the first read cycle. The stalled fill completes once the bank is free.
- R10: A fill to a bank not read in that cycle is accepted with `fillReady` high, even while a gather is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start pulse for a gather |
| startX | input | log2(COLS) | Centre column |
| startY | input | log2(NUM_BANKS) | Centre bank |
| startZ | input | log2(ROWS) | Centre row |
| busy | output | 1 | Gather read cycles in progress |
| fillValid | input | 1 | Fill request |
| fillReady | output | 1 | Fill accepted at this edge |
| fillBank | input | log2(NUM_BANKS) | Fill bank |
| fillRow | input | log2(ROWS) | Fill row |
| fillCol | input | log2(COLS) | Fill column |
| fillData | input | WIDTH | Fill word |
| outValid | output | 1 | Beat valid (lane A) |
| outLast | output | 1 | Final beat of a gather |
| outIdxA | output | 5 | Point index on lane A |
| outDataA | output | WIDTH | Point word on lane A |
| outValidB | output | 1 | Lane B valid |
| outIdxB | output | 5 | Point index on lane B |
| outDataB | output | WIDTH | Point word on lane B |
| yValid | output | 1 | y-neighbour lanes valid |
| yData | output | 8*WIDTH | Eight y-neighbour words |

## Verification
The hardest cases to set up from the ports are fill conflicts, because each one lasts a single cycle. A fill aimed at a y-neighbour bank must land in the first read cycle of a gather, and a fill aimed at the centre bank must land while the bank is still being read. The stimulus starts a gather and then, on the very next cycle, issues a fill to bank y+1 and counts its stall cycles. It next issues a fill to the centre bank and counts those stall cycles. Finally it re-gathers to show that both writes landed and that the first gather saw the old data. Edge centres at bank 0, the last bank and row/column 0 and 7 exercise the wrap, and a start pulse during a gather checks that no extra beats appear.

// File: rtl/stencil_pkg.sv
package stencil_pkg;
  localparam int REACH  = 4;
  localparam int NPTS   = 6 * REACH + 1;
  localparam int NPLANE = 4 * REACH + 1;
  localparam int NY     = 2 * REACH;
  localparam int BEATS  = (NPLANE + 1) / 2;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int IDX_W  = $clog2(NPTS);

  typedef struct packed {
    logic              issue;
    logic              first;
    logic              last;
    logic [BEAT_W-1:0] beat;
  } gatherStrobe_t;

  // signed distance for the k-th point along an axis (k >= 1)
  function automatic int axisOff(input int k);
    int d;
    d = (k + 1) / 2;
    return (k % 2 == 1) ? -d : d;
  endfunction

  function automatic int planeDx(input int p);
    return (p >= 1 && p <= 2 * REACH) ? axisOff(p) : 0;
  endfunction

  function automatic int planeDz(input int p);
    return (p > 2 * REACH) ? axisOff(p - 2 * REACH) : 0;
  endfunction
endpackage

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int DEPTH = 64,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rdEnA,
  input  logic [AW-1:0] addrA,
  input  logic          rdEnB,
  input  logic [AW-1:0] addrB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  doutA,
  output logic [W-1:0]  doutB
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    if (rdEnA) doutA <= mem[addrA];
    if (rdEnB) doutB <= mem[addrB];
  end
endmodule

// File: rtl/stencil_ctrl.sv
module stencil_ctrl
  import stencil_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 4,
  parameter int ZW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startValid,
  input  logic [XW-1:0] startX,
  input  logic [YW-1:0] startY,
  input  logic [ZW-1:0] startZ,
  output logic          busy,
  output gatherStrobe_t strobe,
  output logic [XW-1:0] cx,
  output logic [YW-1:0] cy,
  output logic [ZW-1:0] cz
);
  logic [BEAT_W-1:0] beat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      beat <= '0;
      cx   <= '0;
      cy   <= '0;
      cz   <= '0;
    end else if (!busy) begin
      if (startValid) begin
        busy <= 1'b1;
        beat <= '0;
        cx   <= startX;
        cy   <= startY;
        cz   <= startZ;
      end
    end else if (int'(beat) == BEATS - 1) begin
      busy <= 1'b0;
    end else begin
      beat <= beat + 1'b1;
    end
  end

  always_comb begin
    strobe.issue = busy;
    strobe.first = busy && (beat == '0);
    strobe.last  = busy && (int'(beat) == BEATS - 1);
    strobe.beat  = beat;
  end

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && startValid |=> $stable(cx) && $stable(cy) && $stable(cz));
  p_beat_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> int'(beat) < BEATS);
  p_last_then_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.last |=> !busy);
endmodule

// File: rtl/stencil_dp.sv
module stencil_dp
  import stencil_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int ROWS      = 8,
  parameter int COLS      = 8,
  parameter int WIDTH     = 16,
  localparam int XW = $clog2(COLS),
  localparam int ZW = $clog2(ROWS),
  localparam int YW = $clog2(NUM_BANKS),
  localparam int AW = XW + ZW
) (
  input  logic               clk,
  input  logic               rstN,
  input  gatherStrobe_t      strobe,
  input  logic [XW-1:0]      cx,
  input  logic [YW-1:0]      cy,
  input  logic [ZW-1:0]      cz,
  input  logic               fillValid,
  output logic               fillReady,
  input  logic [YW-1:0]      fillBank,
  input  logic [ZW-1:0]      fillRow,
  input  logic [XW-1:0]      fillCol,
  input  logic [WIDTH-1:0]   fillData,
  output logic               outValid,
  output logic               outLast,
  output logic [IDX_W-1:0]   outIdxA,
  output logic [WIDTH-1:0]   outDataA,
  output logic               outValidB,
  output logic [IDX_W-1:0]   outIdxB,
  output logic [WIDTH-1:0]   outDataB,
  output logic               yValid,
  output logic [NY*WIDTH-1:0] yData
);
  int            pA, pB;
  logic [AW-1:0] addrPA, addrPB, addrCtr, fillAddr;
  logic [YW-1:0] yBank [NY];
  logic [NUM_BANKS-1:0] readMask;
  logic [WIDTH-1:0] doutA [NUM_BANKS];
  logic [WIDTH-1:0] doutB [NUM_BANKS];

  always_comb begin
    pA = 2 * int'(strobe.beat);
    pB = pA + 1;
    addrPA  = {ZW'(int'(cz) + planeDz(pA)), XW'(int'(cx) + planeDx(pA))};
    addrPB  = {ZW'(int'(cz) + planeDz(pB)), XW'(int'(cx) + planeDx(pB))};
    addrCtr = {cz, cx};
    fillAddr = {fillRow, fillCol};
    for (int j = 0; j < NY; j++) yBank[j] = YW'(int'(cy) + axisOff(j + 1));
  end

  assign fillReady = !readMask[fillBank];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic selC, selY, wrEn;
    always_comb begin
      selC = strobe.issue && (cy == YW'(b));
      selY = 1'b0;
      for (int j = 0; j < NY; j++)
        if (strobe.first && yBank[j] == YW'(b)) selY = 1'b1;
    end
    assign readMask[b] = selC | selY;
    assign wrEn = fillValid && fillReady && (fillBank == YW'(b));

    sp_bank #(.DEPTH(ROWS * COLS), .W(WIDTH)) i_bank (
      .clk   (clk),
      .rdEnA (selC | selY),
      .addrA (selC ? addrPA : addrCtr),
      .rdEnB (selC),
      .addrB (addrPB),
      .wrEn  (wrEn),
      .wrAddr(fillAddr),
      .wrData(fillData),
      .doutA (doutA[b]),
      .doutB (doutB[b])
    );

    p_port_a_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
      !(wrEn && (selC || selY)));
  end

  // output stage, aligned with the one-cycle bank read
  logic [BEAT_W-1:0] beatR;
  logic [YW-1:0]     cBankR;
  logic [YW-1:0]     yBankR [NY];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outValidB <= 1'b0;
      yValid    <= 1'b0;
      outLast   <= 1'b0;
      beatR     <= '0;
      cBankR    <= '0;
      for (int j = 0; j < NY; j++) yBankR[j] <= '0;
    end else begin
      outValid  <= strobe.issue;
      outValidB <= strobe.issue && !strobe.last;
      yValid    <= strobe.first;
      outLast   <= strobe.last;
      beatR     <= strobe.beat;
      cBankR    <= cy;
      for (int j = 0; j < NY; j++) yBankR[j] <= yBank[j];
    end
  end

  assign outIdxA  = IDX_W'(2 * int'(beatR));
  assign outIdxB  = IDX_W'(2 * int'(beatR) + 1);
  assign outDataA = doutA[cBankR];
  assign outDataB = doutB[cBankR];

  for (genvar j = 0; j < NY; j++) begin : g_ylane
    assign yData[j*WIDTH +: WIDTH] = doutA[yBankR[j]];
  end

  p_no_fill_collision_r9: assert property (@(posedge clk) disable iff (!rstN)
    fillValid && fillReady |-> !(strobe.issue && fillBank == cy));
  p_fill_free_r10: assert property (@(posedge clk) disable iff (!rstN)
    fillValid && !strobe.first && fillBank != cy |-> fillReady);
  p_last_single_lane_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outLast |-> !outValidB);
  p_y_on_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    yValid |-> outValid && outIdxA == '0);
endmodule

// File: rtl/stencil_scratchpad.sv
module stencil_scratchpad
  import stencil_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int ROWS      = 8,
  parameter int COLS      = 8,
  parameter int WIDTH     = 16,
  localparam int XW = $clog2(COLS),
  localparam int ZW = $clog2(ROWS),
  localparam int YW = $clog2(NUM_BANKS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startValid,
  input  logic [XW-1:0]          startX,
  input  logic [YW-1:0]          startY,
  input  logic [ZW-1:0]          startZ,
  output logic                   busy,
  input  logic                   fillValid,
  output logic                   fillReady,
  input  logic [YW-1:0]          fillBank,
  input  logic [ZW-1:0]          fillRow,
  input  logic [XW-1:0]          fillCol,
  input  logic [WIDTH-1:0]       fillData,
  output logic                   outValid,
  output logic                   outLast,
  output logic [IDX_W-1:0]       outIdxA,
  output logic [WIDTH-1:0]       outDataA,
  output logic                   outValidB,
  output logic [IDX_W-1:0]       outIdxB,
  output logic [WIDTH-1:0]       outDataB,
  output logic                   yValid,
  output logic [NY*WIDTH-1:0]    yData
);
  gatherStrobe_t strobe;
  logic [XW-1:0] cx;
  logic [YW-1:0] cy;
  logic [ZW-1:0] cz;

  stencil_ctrl #(.XW(XW), .YW(YW), .ZW(ZW)) i_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .startX(startX), .startY(startY), .startZ(startZ),
    .busy(busy), .strobe(strobe), .cx(cx), .cy(cy), .cz(cz)
  );

  stencil_dp #(.NUM_BANKS(NUM_BANKS), .ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cx(cx), .cy(cy), .cz(cz),
    .fillValid(fillValid), .fillReady(fillReady), .fillBank(fillBank),
    .fillRow(fillRow), .fillCol(fillCol), .fillData(fillData),
    .outValid(outValid), .outLast(outLast), .outIdxA(outIdxA), .outDataA(outDataA),
    .outValidB(outValidB), .outIdxB(outIdxB), .outDataB(outDataB),
    .yValid(yValid), .yData(yData)
  );
endmodule

// File: tb/test_stencil_scratchpad.sv
module test_stencil_scratchpad;
  localparam int NB = 16, NR = 8, NC = 8, W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [2:0] startX = '0;
  logic [3:0] startY = '0;
  logic [2:0] startZ = '0;
  logic busy;
  logic fillValid = 1'b0;
  logic fillReady;
  logic [3:0] fillBank = '0;
  logic [2:0] fillRow = '0;
  logic [2:0] fillCol = '0;
  logic [W-1:0] fillData = '0;
  logic outValid, outLast, outValidB, yValid;
  logic [4:0] outIdxA, outIdxB;
  logic [W-1:0] outDataA, outDataB;
  logic [8*W-1:0] yData;

  stencil_scratchpad i_stencil_scratchpad (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .startX(startX), .startY(startY), .startZ(startZ), .busy(busy),
    .fillValid(fillValid), .fillReady(fillReady), .fillBank(fillBank),
    .fillRow(fillRow), .fillCol(fillCol), .fillData(fillData),
    .outValid(outValid), .outLast(outLast), .outIdxA(outIdxA), .outDataA(outDataA),
    .outValidB(outValidB), .outIdxB(outIdxB), .outDataB(outDataB),
    .yValid(yValid), .yData(yData)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    int          expCyc;
    logic [4:0]  idxA;
    logic [15:0] dA;
    logic        hasB;
    logic [4:0]  idxB;
    logic [15:0] dB;
    logic        last;
    logic        hasY;
    logic [127:0] y;
  } beat_t;

  beat_t expQ[$];
  logic [W-1:0] model [NB][NR*NC];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int beatsPushed = 0;
  int beatsSeen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int wrapv(input int v, input int m);
    return ((v % m) + m) % m;
  endfunction

  // point p of a stencil centred at (x,y,z) -> stored word (R3, R7)
  function automatic logic [15:0] pointVal(input int x, input int y, input int z, input int p);
    int dx, dy, dz, d, j;
    dx = 0; dy = 0; dz = 0;
    if (p >= 1 && p <= 8) begin
      d = (p + 1) / 2; dx = (p % 2 == 1) ? -d : d;
    end else if (p >= 9 && p <= 16) begin
      d = (p - 7) / 2; dz = ((p - 8) % 2 == 1) ? -d : d;
    end else if (p >= 17) begin
      j = p - 17; d = j / 2 + 1; dy = (j % 2 == 0) ? -d : d;
    end
    return model[wrapv(y + dy, NB)][wrapv(z + dz, NR) * NC + wrapv(x + dx, NC)];
  endfunction

  // driver: push nine expected beats, pulse start
  task automatic startGather(input int x, input int y, input int z);
    beat_t bt;
    while (busy) @(negedge clk);
    for (int k = 0; k < 9; k++) begin
      bt = '0;
      bt.expCyc = cyc + 2 + k;
      bt.idxA = 5'(2 * k);
      bt.dA = pointVal(x, y, z, 2 * k);
      bt.hasB = (k < 8);
      bt.idxB = 5'(2 * k + 1);
      bt.dB = (k < 8) ? pointVal(x, y, z, 2 * k + 1) : '0;
      bt.last = (k == 8);
      bt.hasY = (k == 0);
      for (int j = 0; j < 8; j++) bt.y[j*16 +: 16] = pointVal(x, y, z, 17 + j);
      expQ.push_back(bt);
      beatsPushed++;
    end
    startX = 3'(x); startY = 4'(y); startZ = 3'(z);
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic doFill(input int b, input int r, input int c, input logic [15:0] d,
                        output int stalls);
    fillValid = 1'b1; fillBank = 4'(b); fillRow = 3'(r); fillCol = 3'(c); fillData = d;
    stalls = 0;
    #1;
    while (!fillReady) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    model[b][r * NC + c] = d;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (expQ.size() != 0 && expQ[0].expCyc == cyc) begin
        beat_t e;
        e = expQ.pop_front();
        chk(outValid == 1'b1, "R6", "beat timing", longint'(outValid), 1);
        if (outValid) begin
          beatsSeen++;
          chk(outIdxA == e.idxA, "R4", "lane A index", outIdxA, e.idxA);
          chk(outDataA == e.dA, "R2", "lane A data", outDataA, e.dA);
          chk(outValidB == e.hasB, "R4", "lane B valid", outValidB, e.hasB);
          if (e.hasB) begin
            chk(outIdxB == e.idxB, "R4", "lane B index", outIdxB, e.idxB);
            chk(outDataB == e.dB, "R3", "lane B data", outDataB, e.dB);
          end
          chk(outLast == e.last, "R4", "last flag", outLast, e.last);
          chk(yValid == e.hasY, "R5", "y valid", yValid, e.hasY);
          if (e.hasY)
            for (int j = 0; j < 8; j++)
              chk(yData[j*16 +: 16] == e.y[j*16 +: 16], "R5", "y lane data",
                  yData[j*16 +: 16], e.y[j*16 +: 16]);
        end
      end else if (outValid) begin
        beatsSeen++;
        chk(1'b0, "R8", "unexpected beat", longint'(outIdxA), 0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int st, n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(outValid == 0 && outValidB == 0 && yValid == 0 && outLast == 0, "R1",
        "outputs idle", {outValid, outValidB, yValid, outLast}, 0);
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(fillReady == 1, "R1", "fillReady", fillReady, 1);

    // R2: load every word
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++)
        for (int c = 0; c < NC; c++)
          doFill(b, r, c, 16'(b * 4099 + r * 131 + c * 7 + 3), st);

    // R3/R4/R5: interior gather, and busy length R6
    startGather(3, 5, 4);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == 9, "R6", "busy cycles", n, 9);
    drain();

    // R7: wrap in every axis
    startGather(0, 0, 7);
    startGather(7, 15, 0);
    startGather(1, 2, 6);
    drain();

    // R8: start while busy ignored
    startGather(4, 8, 3);
    repeat (3) begin
      startX = 3'd6; startY = 4'd6; startZ = 3'd6; startValid = 1'b1;
      @(negedge clk);
    end
    startValid = 1'b0;
    drain();
    repeat (10) @(negedge clk);
    chk(beatsSeen == beatsPushed, "R8", "beat total", beatsSeen, beatsPushed);

    // R9: fill to y bank in first read cycle, then to centre bank
    startGather(2, 3, 2);
    doFill(4, 2, 2, 16'hA5A5, st);
    chk(st == 1, "R9", "y-bank stall cycles", st, 1);
    doFill(3, 2, 2, 16'h5A5A, st);
    chk(st == 7, "R9", "centre-bank stall cycles", st, 7);
    drain();

    // R10: fill to an unrelated bank during a gather
    startGather(2, 3, 2);
    doFill(10, 1, 5, 16'hC3C3, st);
    chk(st == 0, "R10", "free-bank stall cycles", st, 0);
    drain();

    // stored values visible afterwards (R9, R10)
    startGather(2, 3, 2);
    startGather(5, 10, 1);
    drain();
    chk(expQ.size() == 0, "R6", "queue empty", expQ.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule